// File: doc/BRIEF.md
# Auto-Stepping Configuration Memory Loader

This block sits between a host with plain read and write strobes and an external synchronous SRAM that holds configuration data. The host sees four registers: a pointer register that holds a 20-bit word address together with three stepping-mode bits, a low data port, a high data port and a status word. Each SRAM location is 64 bits wide. The low port reaches bits 31:0 of the location under the pointer, and the high port reaches bits 63:32.

The stepping-mode bits choose which data-port access advances the pointer. The pointer can advance after each write to the low port, which suits bulk loading. It can advance after each read of the low port, which suits a verify pass. It can also advance after any access to the high port, so that the host can move a 64-bit location as a low word followed by a high word.

The pointer runs from 0 to 0x7FFFF and wraps to 0 after the last location. A wrap sets a sticky flag. The status word also reports a ready signal from the consumer of the loaded data, which the host polls after a load.

Top module: `mem_loader`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 0, all stepping modes are off, the wrap flag is clear and `host_rvalid` is low.
- R2: A write to the pointer register (select 0) loads the address from data bits 19:0 and the stepping modes from bits 31, 30 and 29, and clears the wrap flag. A read of this register returns the address in bits 19:0, the three mode bits in bits 31:29, and zeros elsewhere.
- R3: A write to the low port (select 1) stores the host word into bits 31:0 of the location under the pointer, with host byte lane 7:0 landing in memory bits 7:0. A write to the high port (select 2) stores into bits 63:32. Each memory write enables exactly one word lane.
- R4: With mode bit 31 set, the pointer advances by one after each low-port write. A low-port read leaves the pointer unchanged unless bit 29 is also set.
- R5: With mode bit 30 set, the pointer advances after each high-port read or write. Low-port accesses do not move the pointer unless bit 31 or bit 29 calls for it.
- R6: With mode bit 29 set, the pointer advances by one after each low-port read.
- R7: A read of a data port raises `host_rvalid` exactly one cycle later. The returned word comes from the location the pointer held in the read cycle, and any advance takes effect after that read.
- R8: Advancing from location 0x7FFFF wraps the pointer to 0 and sets the wrap flag (status bit 0). The flag stays set until the pointer register is written.
- R9: A status read (select 3) returns `ready_in`, as sampled in the read cycle, in bit 31 and the wrap flag in bit 0, with zeros elsewhere.
- R10: With all mode bits clear, no data-port access changes the pointer.
- R11: Accesses to the pointer or status register never enable the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_sel | input | 2 | Register select: 0 pointer, 1 low port, 2 high port, 3 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid while host_rvalid is high |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| ready_in | input | 1 | Consumer ready indication |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_wmask | output | 2 | Word-lane write enables: bit 0 low word, bit 1 high word |
| mem_addr | output | 20 | SRAM word address, equal to the current pointer |
| mem_wdata | output | 64 | SRAM write data, with the host word on both lanes |
| mem_rdata | input | 64 | SRAM read data, one cycle after a read enable |

## Verification
The properties assume that the host never raises `host_wr` and `host_rd` in the same cycle, and that the SRAM returns read data exactly one cycle after an enabled read. The stimulus issues every access through single-strobe tasks that drive one strobe for one cycle and then idle. The memory model returns data on the clock edge that follows the enable. The wrap checks start from a pointer loaded near 0x7FFFF, so they never need a long run of steps.

// File: rtl/mem_loader_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the configuration memory loader.
// Assumes a 2-bit register select on the host side.
package mem_loader_pkg;
    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    // Mode bit positions within the pointer register (index into the mode vector)
    localparam int MODE_LOW_WR  = 2;   // host bit 31
    localparam int MODE_HIGH    = 1;   // host bit 30
    localparam int MODE_LOW_RD  = 0;   // host bit 29
    localparam int MODE_W       = 3;
endpackage

// File: rtl/loader_pointer.sv
`timescale 1ns/1ps
// Word pointer with wrap detection.
// Loads a start address, steps by one on request, wraps to zero after the
// last location and keeps a sticky wrap flag until the next load.
// Assumes load and step are never high together.
module loader_pointer #(
    parameter int ADDR_W    = 20,
    parameter int NUM_WORDS = 'h80000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              wrapped
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_WORDS - 1);

    // Pointer register and sticky wrap flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr    <= '0;
            wrapped <= 1'b0;
        end else if (load) begin
            addr    <= load_addr;
            wrapped <= 1'b0;
        end else if (step) begin
            if (addr >= LAST) begin
                addr    <= '0;
                wrapped <= 1'b1;
            end else begin
                addr    <= addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/loader_ctrl.sv
`timescale 1ns/1ps
// Access decoder and mode register.
// Turns host strobes into memory enables, lane masks, pointer loads and
// pointer steps according to the stored stepping modes.
// Assumes host_wr and host_rd are mutually exclusive.
module loader_ctrl
    import mem_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_sel,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [MODE_W-1:0] mode,
    output logic              ptr_load,
    output logic              ptr_step,
    output logic              mem_en,
    output logic              mem_we,
    output logic [1:0]        mem_wmask
);
    reg_sel_e sel;
    logic     is_low, is_high;

    assign sel     = reg_sel_e'(host_sel);
    assign is_low  = (sel == SEL_LOW);
    assign is_high = (sel == SEL_HIGH);

    // Stepping-mode register, written with the pointer
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= '0;
        else if (ptr_load)
            mode <= mode_wdata;
    end

    // Decode of the current host access
    always_comb begin
        ptr_load  = host_wr && (sel == SEL_PTR);
        mem_en    = (host_wr || host_rd) && (is_low || is_high);
        mem_we    = host_wr && (is_low || is_high);
        mem_wmask = {host_wr && is_high, host_wr && is_low};
        ptr_step  = (host_wr && is_low && mode[MODE_LOW_WR])
                 || (host_rd && is_low && mode[MODE_LOW_RD])
                 || ((host_wr || host_rd) && is_high && mode[MODE_HIGH]);
    end
endmodule

// File: rtl/loader_readback.sv
`timescale 1ns/1ps
// Read return path.
// Registers the selected register word and the port choice at the read
// strobe, then presents either that word or the SRAM output one cycle later.
// Assumes the SRAM delivers read data on the edge after its enable.
module loader_readback
    import mem_loader_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_rd,
    input  logic [1:0]          host_sel,
    input  logic [DATA_W-1:0]   ptr_word,
    input  logic [DATA_W-1:0]   stat_word,
    input  logic [2*DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rvalid
);
    reg_sel_e          sel_q;
    logic [DATA_W-1:0] word_q;

    // Capture the access type and register word at the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            sel_q       <= SEL_PTR;
            word_q      <= '0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) begin
                sel_q  <= reg_sel_e'(host_sel);
                word_q <= (reg_sel_e'(host_sel) == SEL_PTR) ? ptr_word : stat_word;
            end
        end
    end

    // Select the returned word
    always_comb begin
        case (sel_q)
            SEL_LOW:  host_rdata = mem_rdata[DATA_W-1:0];
            SEL_HIGH: host_rdata = mem_rdata[2*DATA_W-1:DATA_W];
            default:  host_rdata = word_q;
        endcase
    end
endmodule

// File: rtl/mem_loader.sv
`timescale 1ns/1ps
// Configuration memory loader top.
// Host register front end over a 64-bit synchronous SRAM: one pointer
// register with stepping modes, a low and a high 32-bit data port, and a
// status word with consumer ready and sticky wrap flag.
// Assumes one host strobe per cycle and a one-cycle SRAM read latency.
module mem_loader
    import mem_loader_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 20,
    parameter int NUM_WORDS = 'h80000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [1:0]          host_sel,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rvalid,
    input  logic                ready_in,
    output logic                mem_en,
    output logic                mem_we,
    output logic [1:0]          mem_wmask,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [2*DATA_W-1:0] mem_wdata,
    input  logic [2*DATA_W-1:0] mem_rdata
);
    localparam int PTR_PAD  = DATA_W - MODE_W - ADDR_W;
    localparam int STAT_PAD = DATA_W - 2;

    logic [MODE_W-1:0] mode;
    logic              ptr_load, ptr_step, wrapped;
    logic [DATA_W-1:0] ptr_word, stat_word;

    loader_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .mode_wdata (host_wdata[DATA_W-1 -: MODE_W]),
        .mode       (mode),
        .ptr_load   (ptr_load),
        .ptr_step   (ptr_step),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_wmask  (mem_wmask)
    );

    loader_pointer #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_addr (host_wdata[ADDR_W-1:0]),
        .step      (ptr_step),
        .addr      (mem_addr),
        .wrapped   (wrapped)
    );

    // Register words presented to the read path
    assign ptr_word  = {mode, {PTR_PAD{1'b0}}, mem_addr};
    assign stat_word = {ready_in, {STAT_PAD{1'b0}}, wrapped};

    // Host word driven on both lanes; the mask picks the lane written
    assign mem_wdata = {host_wdata, host_wdata};

    loader_readback #(.DATA_W(DATA_W)) u_rb (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_rd     (host_rd),
        .host_sel    (host_sel),
        .ptr_word    (ptr_word),
        .stat_word   (stat_word),
        .mem_rdata   (mem_rdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );
endmodule

// File: rtl/mem_loader_sva.sv
`timescale 1ns/1ps
// Property checker for mem_loader, attached by bind.
// Assumes host_wr and host_rd are never high together.
module mem_loader_sva #(
    parameter int ADDR_W    = 20,
    parameter int NUM_WORDS = 'h80000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [1:0]        host_sel,
    input logic [ADDR_W-1:0] host_wdata_addr,
    input logic              host_rvalid,
    input logic              mem_en,
    input logic              mem_we,
    input logic [1:0]        mem_wmask,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              ptr_step,
    input logic              wrapped
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_WORDS - 1);

    logic ptr_wr;
    assign ptr_wr = host_wr && (host_sel == 2'd0);

    p_rvalid_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);

    p_no_spurious_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);

    p_pointer_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (mem_addr == $past(host_wdata_addr)) && !wrapped);

    p_step_advances_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_step && mem_addr != LAST) |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    p_wrap_to_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_step && mem_addr == LAST) |=> (mem_addr == '0) && wrapped);

    p_wrap_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped && !ptr_wr) |=> wrapped);

    p_pointer_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_step && !ptr_wr) |=> $stable(mem_addr));

    p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> $countones(mem_wmask) == 1);

    p_reg_no_mem_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel == 2'd0 || host_sel == 2'd3) |-> !mem_en);
endmodule

bind mem_loader mem_loader_sva #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_sva (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_wr         (host_wr),
    .host_rd         (host_rd),
    .host_sel        (host_sel),
    .host_wdata_addr (host_wdata[ADDR_W-1:0]),
    .host_rvalid     (host_rvalid),
    .mem_en          (mem_en),
    .mem_we          (mem_we),
    .mem_wmask       (mem_wmask),
    .mem_addr        (mem_addr),
    .ptr_step        (ptr_step),
    .wrapped         (wrapped)
);

// File: tb/test_mem_loader.sv
`timescale 1ns/1ps
// Self-checking bench for mem_loader with a behavioural reference model.
module test_mem_loader;
    localparam int LAST = 'h7FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        ready_in = 1'b0;
    logic        mem_en, mem_we;
    logic [1:0]  mem_wmask;
    logic [19:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit prev_rd = 1'b0;

    // Reference model state
    int          m_addr = 0;
    bit          m_wlo = 0, m_hi = 0, m_rlo = 0, m_ovf = 0;
    logic [63:0] ref_mem [int];
    logic [63:0] sram [int];

    always #4 clk = ~clk;

    mem_loader i_mem_loader (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .ready_in(ready_in), .mem_en(mem_en),
        .mem_we(mem_we), .mem_wmask(mem_wmask), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Synchronous SRAM model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                logic [63:0] w;
                w = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 64'd0;
                if (mem_wmask[0]) w[31:0]  = mem_wdata[31:0];
                if (mem_wmask[1]) w[63:32] = mem_wdata[63:32];
                sram[int'(mem_addr)] = w;
            end else begin
                mem_rdata <= sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 64'd0;
            end
        end
        prev_rd <= host_rd && rst_n;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison of the read-valid timing against the model (R7)
    always @(negedge clk) begin
        if (running) chk("R7 rvalid timing", {63'd0, host_rvalid}, {63'd0, prev_rd});
    end

    function automatic void m_step();
        if (m_addr == LAST) begin
            m_addr = 0;
            m_ovf  = 1;
        end else begin
            m_addr = m_addr + 1;
        end
    endfunction

    task automatic bus_write(input logic [1:0] sel, input logic [31:0] d);
        logic [63:0] cur;
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        cur = ref_mem.exists(m_addr) ? ref_mem[m_addr] : 64'd0;
        case (sel)
            2'd0: begin
                m_addr = int'(d[19:0]);
                m_wlo = d[31]; m_hi = d[30]; m_rlo = d[29]; m_ovf = 0;
            end
            2'd1: begin
                cur[31:0] = d; ref_mem[m_addr] = cur;
                if (m_wlo) m_step();
            end
            2'd2: begin
                cur[63:32] = d; ref_mem[m_addr] = cur;
                if (m_hi) m_step();
            end
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [1:0] sel, input string req);
        logic [63:0] cur;
        logic [31:0] exp;
        logic        rdy;
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        rdy = ready_in;
        #1;
        if (sel == 2'd0 || sel == 2'd3)
            chk("R11 no memory enable on register read", {63'd0, mem_en}, 64'd0);
        @(negedge clk);
        host_rd = 1'b0;
        cur = ref_mem.exists(m_addr) ? ref_mem[m_addr] : 64'd0;
        case (sel)
            2'd0: exp = {m_wlo, m_hi, m_rlo, 9'd0, 20'(m_addr)};
            2'd1: exp = cur[31:0];
            2'd2: exp = cur[63:32];
            default: exp = {rdy, 30'd0, m_ovf};
        endcase
        chk(req, {32'd0, host_rdata}, {32'd0, exp});
        if (sel == 2'd1 && m_rlo) m_step();
        if (sel == 2'd2 && m_hi)  m_step();
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rvalid low in reset", {63'd0, host_rvalid}, 64'd0);
        rst_n = 1'b1;
        running = 1'b1;

        // R1 reset state through the register interface
        bus_read(2'd0, "R1 pointer after reset");
        bus_read(2'd3, "R1 R9 status after reset");

        // R4 sequential load through the low port
        bus_write(2'd0, 32'h8000_0010);
        bus_write(2'd1, 32'h0403_0201);
        bus_write(2'd1, 32'h0807_0605);
        bus_write(2'd1, 32'hDEAD_BEEF);
        bus_read(2'd0, "R2 R4 pointer after three writes");
        bus_read(2'd1, "R4 low read at unwritten location");
        bus_read(2'd0, "R4 low read does not step");
        chk("R3 byte lane 0 in memory bits 7:0", {56'd0, sram[16][7:0]}, 64'h01);
        chk("R3 high lane untouched by low write", sram[16], 64'h0000_0000_0403_0201);

        // R6 R7 verify reads stepping on low-port reads
        bus_write(2'd0, 32'h2000_0010);
        bus_read(2'd1, "R6 R7 verify word 0");
        bus_read(2'd1, "R6 R7 verify word 1");
        bus_read(2'd1, "R6 R7 verify word 2");
        bus_read(2'd0, "R6 pointer after three reads");

        // R5 paired 64-bit accesses
        bus_write(2'd0, 32'h4000_0100);
        bus_write(2'd1, 32'hAAAA_0001);
        bus_write(2'd2, 32'hBBBB_0001);
        bus_write(2'd1, 32'hAAAA_0002);
        bus_write(2'd2, 32'hBBBB_0002);
        bus_read(2'd0, "R5 pointer after two pairs");
        chk("R3 R5 both lanes of one location", sram['h100], 64'hBBBB_0001_AAAA_0001);
        bus_write(2'd0, 32'h4000_0100);
        bus_read(2'd1, "R5 low read no step");
        bus_read(2'd2, "R5 high read steps");
        bus_read(2'd1, "R5 low word next location");
        bus_read(2'd2, "R5 high word next location");
        bus_read(2'd0, "R5 pointer after reads");

        // R10 accesses with every mode bit clear
        bus_write(2'd0, 32'h0000_0020);
        bus_write(2'd1, 32'h1234_5678);
        bus_read(2'd1, "R10 low read back");
        bus_write(2'd2, 32'h9ABC_DEF0);
        bus_read(2'd2, "R10 high read back");
        bus_read(2'd0, "R10 pointer unchanged");

        // R8 wrap at the last location
        bus_write(2'd0, 32'h8007_FFFE);
        bus_write(2'd1, 32'h0000_00FE);
        bus_read(2'd3, "R8 no wrap before last");
        bus_write(2'd1, 32'h0000_00FF);
        bus_read(2'd3, "R8 wrap flag set");
        bus_read(2'd0, "R8 pointer wrapped to zero");
        bus_write(2'd1, 32'h0000_0100);
        bus_read(2'd3, "R8 wrap flag sticky");
        bus_write(2'd0, 32'h0000_0005);
        bus_read(2'd3, "R8 R2 wrap flag cleared by pointer write");

        // R9 ready reporting
        ready_in = 1'b1;
        bus_read(2'd3, "R9 ready high");
        ready_in = 1'b0;
        bus_read(2'd3, "R9 ready low");

        @(negedge clk);
        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule